// File: doc/BRIEF.md
# Trace Line Buffer with Word Readout

This block keeps a circular on-chip record of 64-bit trace lines and lets a host read that record back through a narrow 16-bit register port. While the arm input is high, each valid capture beat is written into the next line of the memory. After the last line the memory wraps, so the newest lines overwrite the oldest. A new session begins on the first cycle of each arm period, and that cycle clears the write position, the line count and the wrap flag.

While the block is disarmed, the host unlocks the buffer with a single aligned 16-bit write to the data register. It then reads the captured lines, oldest first, as four 16-bit words per line. A separate count register reports how many lines hold valid data. The memory, the count and the wrap flag are not cleared by system reset, so a session recorded before a reset stays readable once the buffer has been unlocked again. A secured input forces every read to zero and blocks unlocking.

The readout side is a three-state machine. LOCKED is entered on reset or while armed, and data reads in this state return zero. READY delivers words. DRAINED is entered after the final word of the last valid line, and data reads in this state also return zero. The transitions are as follows:
- LOCKED goes to READY on an unlock write, or to DRAINED if the count is zero.
- READY goes to LOCKED when arm is high.
- READY goes to DRAINED when the last valid word is read.
- DRAINED goes to LOCKED when arm is high.
- READY and DRAINED both go back to READY, or to DRAINED if the count is zero, on an unlock write, which also restarts the read position.

Top module: `tbuf_readout`

## Requirements
- R1: While arm is high, a read of the data register returns zero and does not change the read position.
- R2: The buffer unlocks only on a write with byte address 0 and byte enables 2'b11 while arm and secure are both low. Each such write sets the read position to the oldest line, word 0. Any other write leaves a locked buffer locked.
- R3: A read whose byte enables are not 2'b11, or whose byte address is odd, returns zero and leaves the read position unchanged.
- R4: Lines are delivered oldest first. Without a wrap the oldest line is line 0. After a wrap the oldest line is the one the next capture would overwrite.
- R5: Each line is delivered as four words, bits 15:0 first and bits 63:48 last, with no bits skipped.
- R6: A read with byte address 2 and byte enables 2'b11 returns the number of valid lines. This count saturates at DEPTH and does not decrease as lines are read.
- R7: System reset leaves the memory, the count and the wrap flag intact and puts the readout in LOCKED. After the next unlock write, the pre-reset session reads back from its oldest line.
- R8: Bit 63 of each stored line holds the capture's access-type bit, where 1 means a read access and 0 means a write access. Bits 62:0 hold the capture payload.
- R9: Once the last word of the last valid line has been read, further data reads return zero until the next unlock write.
- R10: While secure is high, every read returns zero and unlock writes have no effect.
- R11: The first cycle of each arm period starts a new session: the count becomes 0, the wrap flag clears, and the next capture goes to line 0. A capture in that first cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset (readout side only) |
| arm | input | 1 | High while tracing; locks the buffer |
| secure | input | 1 | Secured-system condition; forces zero reads, blocks unlock |
| cap_valid | input | 1 | Capture beat valid |
| cap_data | input | 63 | Capture payload, stored in line bits 62:0 |
| cap_is_read | input | 1 | Access type of the capture, stored in line bit 63 (1 = read) |
| bus_addr | input | 2 | Byte address: 0 = data register, 2 = count register |
| bus_be | input | 2 | Byte enables; 2'b11 = full word |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (written value carries no meaning) |
| bus_rdata | output | 16 | Read data, registered |

## Verification
Read data is registered: `bus_rdata` takes its new value at the clock edge that samples `bus_rd`, so the bench raises a read strobe at one falling edge and samples at the next falling edge. An unlock write takes effect at the edge that samples it, so the next read already returns the oldest word. A capture updates the count at its own edge, and arming clears the session at the first edge that sees arm high, so the bench waits one extra cycle after raising arm before it drives captures. Because every expected value is due exactly one edge after its stimulus, each check samples at the falling edge that follows.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED  = 2'd0,
        ST_READY   = 2'd1,
        ST_DRAINED = 2'd2
    } rd_state_e;

    localparam logic [1:0] ADDR_DATA  = 2'd0;
    localparam logic [1:0] ADDR_COUNT = 2'd2;
    localparam logic [1:0] BE_WORD    = 2'b11;
    localparam int unsigned LINE_W    = 64;
    localparam int unsigned WORD_W    = 16;
endpackage

// File: rtl/tbuf_store.sv
module tbuf_store #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [63:0]   wr_line,
    input  logic [AW-1:0] rd_addr,
    output logic [63:0]   rd_line
);
    // No reset: contents must outlive a system reset.
    logic [63:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_line;
    end

    assign rd_line = mem_q[rd_addr];
endmodule

// File: rtl/tbuf_session.sv
module tbuf_session #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          cap_valid,
    output logic          cap_we,
    output logic [AW-1:0] wr_ptr,
    output logic [CW-1:0] line_cnt,
    output logic          wrapped
);
    logic arm_q;
    logic start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= arm;
    end

    assign start  = arm & ~arm_q;
    assign cap_we = arm & arm_q & cap_valid;

    // Session state is retained through system reset on purpose.
    always_ff @(posedge clk) begin
        if (start) begin
            wr_ptr   <= '0;
            line_cnt <= '0;
            wrapped  <= 1'b0;
        end else if (cap_we) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (wr_ptr == AW'(DEPTH - 1)) wrapped <= 1'b1;
            if (line_cnt != CW'(DEPTH))   line_cnt <= line_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tbuf_rd_fsm.sv
module tbuf_rd_fsm
    import tbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          secure,
    input  logic [1:0]    bus_addr,
    input  logic [1:0]    bus_be,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [63:0]   rd_line,
    input  logic [CW-1:0] line_cnt,
    input  logic [AW-1:0] wr_ptr,
    input  logic          wrapped,
    output logic [AW-1:0] rd_addr,
    output logic [15:0]   bus_rdata
);
    rd_state_e     state_q, state_d;
    logic [CW-1:0] line_off_q;
    logic [1:0]    word_idx_q;
    logic          data_hit, cnt_hit, unlock, fetch, last_word;
    logic [AW-1:0] oldest;
    rd_state_e     open_state;

    assign data_hit   = (bus_addr == ADDR_DATA)  && (bus_be == BE_WORD);
    assign cnt_hit    = (bus_addr == ADDR_COUNT) && (bus_be == BE_WORD);
    assign unlock     = bus_wr && data_hit && !arm && !secure;
    assign fetch      = bus_rd && data_hit && !arm && !secure && (state_q == ST_READY);
    assign last_word  = (word_idx_q == 2'd3) && ((line_off_q + 1'b1) == line_cnt);
    assign oldest     = wrapped ? wr_ptr : '0;
    assign rd_addr    = oldest + line_off_q[AW-1:0];
    assign open_state = (line_cnt == '0) ? ST_DRAINED : ST_READY;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (unlock) state_d = open_state;
            end
            ST_READY: begin
                if (arm)                    state_d = ST_LOCKED;
                else if (unlock)            state_d = open_state;
                else if (fetch && last_word) state_d = ST_DRAINED;
            end
            ST_DRAINED: begin
                if (arm)         state_d = ST_LOCKED;
                else if (unlock) state_d = open_state;
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_off_q <= '0;
            word_idx_q <= '0;
            bus_rdata  <= '0;
        end else begin
            if (unlock) begin
                line_off_q <= '0;
                word_idx_q <= '0;
            end else if (fetch) begin
                word_idx_q <= word_idx_q + 1'b1;
                if (word_idx_q == 2'd3) line_off_q <= line_off_q + 1'b1;
            end
            if (bus_rd) begin
                if (secure)       bus_rdata <= '0;
                else if (cnt_hit) bus_rdata <= 16'(line_cnt);
                else if (fetch)   bus_rdata <= rd_line[{word_idx_q, 4'b0000} +: 16];
                else              bus_rdata <= '0;
            end
        end
    end
endmodule

// File: rtl/tbuf_readout.sv
module tbuf_readout
    import tbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm,
    input  logic        secure,
    input  logic        cap_valid,
    input  logic [62:0] cap_data,
    input  logic        cap_is_read,
    input  logic [1:0]  bus_addr,
    input  logic [1:0]  bus_be,
    input  logic        bus_rd,
    input  logic        bus_wr,
    output logic [15:0] bus_rdata
);
    logic          cap_we;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_addr;
    logic [CW-1:0] line_cnt;
    logic          wrapped;
    logic [63:0]   rd_line;

    tbuf_session #(.DEPTH(DEPTH)) u_session (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .cap_valid(cap_valid),
        .cap_we   (cap_we),
        .wr_ptr   (wr_ptr),
        .line_cnt (line_cnt),
        .wrapped  (wrapped)
    );

    tbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .wr_en  (cap_we),
        .wr_addr(wr_ptr),
        .wr_line({cap_is_read, cap_data}),
        .rd_addr(rd_addr),
        .rd_line(rd_line)
    );

    tbuf_rd_fsm #(.DEPTH(DEPTH)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .secure   (secure),
        .bus_addr (bus_addr),
        .bus_be   (bus_be),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .rd_line  (rd_line),
        .line_cnt (line_cnt),
        .wr_ptr   (wr_ptr),
        .wrapped  (wrapped),
        .rd_addr  (rd_addr),
        .bus_rdata(bus_rdata)
    );
endmodule

// File: rtl/tbuf_readout_chk.sv
module tbuf_readout_chk #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm,
    input logic          secure,
    input logic [1:0]    bus_addr,
    input logic [1:0]    bus_be,
    input logic          bus_rd,
    input logic [15:0]   bus_rdata,
    input logic [CW-1:0] line_cnt
);
    // R1
    armed_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && arm && bus_addr == 2'd0) |=> (bus_rdata == 16'd0));

    // R3
    misaligned_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_be != 2'b11 || bus_addr[0])) |=> (bus_rdata == 16'd0));

    // R10
    secure_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && secure) |=> (bus_rdata == 16'd0));

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_cnt <= CW'(DEPTH)));

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm) |=> $stable(line_cnt));
endmodule

bind tbuf_readout tbuf_readout_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .secure   (secure),
    .bus_addr (bus_addr),
    .bus_be   (bus_be),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .line_cnt (line_cnt)
);

// File: tb/tbuf_readout_tb.sv
`timescale 1ns/1ps
module tbuf_readout_tb;
    localparam int DEPTH = 64;
    localparam int NVEC  = 5;
    localparam logic [63:0] VEC [NVEC] = '{
        64'h1122_3344_5566_7788,
        64'hF0E1_D2C3_B4A5_9687,
        64'h0000_FFFF_0000_FFFF,
        64'h8001_4002_2003_1004,
        64'h7ABC_DEF0_1357_9BDF
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0, secure = 1'b0, cap_valid = 1'b0, cap_is_read = 1'b0;
    logic [62:0] cap_data = '0;
    logic [1:0]  bus_addr = '0, bus_be = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_rdata;
    int nvec = 0, nerr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tbuf_readout #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .secure(secure),
        .cap_valid(cap_valid), .cap_data(cap_data), .cap_is_read(cap_is_read),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [63:0] pat(input int k);
        return 64'h0F1E_2D3C_4B5A_6978 ^ {4{16'(k)}};
    endfunction

    function automatic logic [63:0] stored(input logic [63:0] d, input bit r);
        return {r, d[62:0]};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input logic [1:0] be, output logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_be = be; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] be);
        @(negedge clk); bus_addr = a; bus_be = be; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic cap(input logic [63:0] d, input bit r);
        @(negedge clk); cap_valid = 1'b1; cap_data = d[62:0]; cap_is_read = r;
        @(negedge clk); cap_valid = 1'b0;
    endtask

    task automatic arm_on;
        @(negedge clk); arm = 1'b1;
        @(negedge clk);
    endtask

    task automatic arm_off;
        @(negedge clk); arm = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++; nvec++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [63:0] ln;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: LOCKED after reset, data reads give zero
        rd(2'd0, 2'b11, d); check("R7 reset locked", d, 16'h0);

        // R11: new session, capture table vectors
        arm_on();
        for (int i = 0; i < NVEC; i++) cap(VEC[i], i[0]);
        rd(2'd0, 2'b11, d); check("R1 armed read", d, 16'h0);
        wr(2'd0, 2'b11);                       // R2: ignored while armed
        arm_off();
        rd(2'd0, 2'b11, d); check("R2 still locked after armed write", d, 16'h0);
        wr(2'd1, 2'b11);
        rd(2'd0, 2'b11, d); check("R2 misaligned write no unlock", d, 16'h0);
        wr(2'd0, 2'b01);
        rd(2'd0, 2'b11, d); check("R2 byte write no unlock", d, 16'h0);
        wr(2'd0, 2'b11);
        rd(2'd2, 2'b11, d); check("R6 count", d, 16'd5);

        // R4 R5 R8: table walk, oldest first, low word first
        for (int i = 0; i < NVEC; i++) begin
            ln = stored(VEC[i], i[0]);
            for (int w = 0; w < 4; w++) begin
                rd(2'd0, 2'b11, d); check("R5 word order", d, ln[16*w +: 16]);
                if (i == 0 && w == 0) begin
                    rd(2'd1, 2'b11, d); check("R3 odd address", d, 16'h0);
                    rd(2'd0, 2'b01, d); check("R3 byte read", d, 16'h0);
                end
            end
        end
        rd(2'd0, 2'b11, d); check("R9 past end", d, 16'h0);
        rd(2'd2, 2'b11, d); check("R6 no decrement", d, 16'd5);
        wr(2'd0, 2'b11);
        rd(2'd0, 2'b11, d); check("R2 restart oldest", d, VEC[0][15:0]);
        rd(2'd0, 2'b11, d); check("R2 restart next", d, VEC[0][31:16]);
        ln = stored(VEC[1], 1'b1);
        wr(2'd0, 2'b11);
        for (int w = 0; w < 4; w++) rd(2'd0, 2'b11, d);
        rd(2'd0, 2'b11, d); check("R8 read flag line1 w0", d, ln[15:0]);
        rd(2'd0, 2'b11, d); rd(2'd0, 2'b11, d);
        rd(2'd0, 2'b11, d); check("R8 read flag bit63", d, ln[63:48]);

        // R4: wrapped session, DEPTH+3 captures
        arm_on();
        for (int j = 0; j < DEPTH + 3; j++) cap(pat(j), j[0]);
        arm_off();
        wr(2'd0, 2'b11);
        rd(2'd2, 2'b11, d); check("R6 saturate", d, 16'(DEPTH));
        for (int i = 0; i < DEPTH; i++) begin
            ln = stored(pat(i + 3), i[0] ^ 1'b1);
            for (int w = 0; w < 4; w++) begin
                rd(2'd0, 2'b11, d); check("R4 wrapped order", d, ln[16*w +: 16]);
            end
        end
        rd(2'd0, 2'b11, d); check("R9 past end wrapped", d, 16'h0);

        // R7 R10: reset retention and secured condition
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(2'd0, 2'b11, d); check("R7 locked after reset", d, 16'h0);
        secure = 1'b1;
        rd(2'd2, 2'b11, d); check("R10 secure count", d, 16'h0);
        wr(2'd0, 2'b11);
        secure = 1'b0;
        rd(2'd0, 2'b11, d); check("R10 unlock blocked", d, 16'h0);
        rd(2'd2, 2'b11, d); check("R7 count retained", d, 16'(DEPTH));
        wr(2'd0, 2'b11);
        ln = stored(pat(3), 1'b1);
        rd(2'd0, 2'b11, d); check("R7 oldest after reset", d, ln[15:0]);
        secure = 1'b1;
        rd(2'd0, 2'b11, d); check("R10 secure data", d, 16'h0);
        secure = 1'b0;
        rd(2'd0, 2'b11, d); check("R10 no advance", d, ln[31:16]);

        // R11: new arm clears session
        arm_on();
        rd(2'd2, 2'b11, d); check("R11 count cleared", d, 16'd0);
        cap(VEC[4], 1'b0);
        cap(VEC[2], 1'b1);
        arm_off();
        rd(2'd2, 2'b11, d); check("R11 count two", d, 16'd2);
        wr(2'd0, 2'b11);
        ln = stored(VEC[4], 1'b0);
        rd(2'd0, 2'b11, d); check("R11 line0 from start", d, ln[15:0]);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule